// File: doc/BRIEF.md
# Paged DRAM Address Multiplexer and Strobe Sequencer

This block turns one CPU memory request into a complete multiplexed DRAM access. The requester presents a 13-bit in-page offset, which bypasses address translation, and a 5-bit bank number that a paging unit has already substituted for the upper address bits. Offset and bank together make an 18-bit memory address. The block splits that address into a 9-bit row word and a 9-bit column word and drives them in turn onto a shared 9-bit address bus. It also sequences the active-low row and column strobes, and for writes it pulses exactly one of two active-low byte-lane write enables.

The mapping onto the bus is deliberately irregular. Offset bit 0 never reaches the bus; it only picks the byte lane. The top bank bit appears twice, as the most significant bit of both the row word and the column word.

Requests enter on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is in progress, so a requester may hold `req_valid` asserted and change its address fields while it waits, and nothing is captured until ready returns. The row strobe waits for a system-clock edge at which the slow bus phase input `phase_hi` is high.

Top module: `dram_addr_seq`

## Requirements
- R1: When no access is in progress (including right after reset), `req_ready` is 1, `row_stb_n` and `col_stb_n` are 1, and `lane_we_n` is 2'b11.
- R2: A request is captured only on an edge with `req_valid` and `req_ready` both 1. `req_ready` is 0 from the capturing edge until the strobes have returned high, and request inputs presented during that time have no effect on the access.
- R3: The row word is {bank[4], offset[8:1]}. It is on `mux_addr` from the edge after capture until the edge after the row strobe falls.
- R4: The column word is {bank[4], bank[3:0], offset[12:9]}. It is on `mux_addr` from one edge after the row strobe falls until the next request is captured.
- R5: `row_stb_n` falls only at an edge where `phase_hi` is 1, and not before the first edge after capture. The row word has then been stable on the bus for at least one clock.
- R6: The bus changes from row word to column word exactly one clock after `row_stb_n` falls, and `col_stb_n` falls one clock after that.
- R7: For a read (`req_write`=0), `lane_we_n` stays 2'b11 for the whole access.
- R8: For a write, only one lane is enabled: lane 0 (`lane_we_n`=2'b10) for an even offset and lane 1 (`lane_we_n`=2'b01) for an odd offset. It is low for exactly COL_CYCLES clocks, starting at the same edge as the column strobe, and it is released one clock before the strobes rise.
- R9: `col_stb_n` stays low for COL_CYCLES+1 clocks, and then both strobes rise at the same edge. `req_ready` is high from that edge.
- R10: Two offsets that differ only in bit 0 produce identical row and column words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_offset | input | 13 | In-page offset, untranslated address bits |
| req_bank | input | 5 | Bank number from the paging unit |
| phase_hi | input | 1 | High while the slow bus phase permits the row strobe |
| mux_addr | output | 9 | Multiplexed DRAM address bus |
| row_stb_n | output | 1 | Row strobe, active low |
| col_stb_n | output | 1 | Column strobe, active low |
| lane_we_n | output | 2 | Byte-lane write enables, active low |

## Verification
The hardest state to reach from the ports is a request that has been captured while `phase_hi` stays low for several clocks. During that wait the row word must stay on the bus with the strobes idle. In the same window, a second request pushing on `req_valid` with different fields must be ignored. The bench controls `phase_hi` directly and holds it low for a chosen number of edges after capture. In the busy-window scenario it keeps `req_valid` high with inverted offset, bank and direction. Every bus and strobe value is then compared clock by clock against the first request's expected timeline.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RHOLD,
    ST_CSET,
    ST_CACT,
    ST_CREL
  } seq_state_t;

  localparam logic [1:0] LANES_OFF = 2'b11;

endpackage

// File: rtl/dram_addr_map.sv
module dram_addr_map #(
  parameter int OFFSET_W = 13,
  parameter int BANK_W   = 5,
  parameter int BUS_W    = 9
) (
  input  logic [OFFSET_W-1:0] offset,
  input  logic [BANK_W-1:0]   bank,
  output logic [BUS_W-1:0]    row_word,
  output logic [BUS_W-1:0]    col_word,
  output logic [1:0]          lane_sel
);

  localparam int ROW_ADDR_BITS = BUS_W - 1;
  localparam int COL_ADDR_BITS = OFFSET_W - 1 - ROW_ADDR_BITS;
  localparam int BANK_LO_BITS  = BANK_W - 1;

  // row word: offset bits above the lane bit, then the top bank bit
  for (genvar i = 0; i < ROW_ADDR_BITS; i++) begin : g_row
    assign row_word[i] = offset[i + 1];
  end
  assign row_word[BUS_W-1] = bank[BANK_W-1];

  // column word: remaining offset bits, low bank bits, top bank bit again
  for (genvar i = 0; i < COL_ADDR_BITS; i++) begin : g_col_off
    assign col_word[i] = offset[ROW_ADDR_BITS + 1 + i];
  end
  for (genvar i = 0; i < BANK_LO_BITS; i++) begin : g_col_bank
    assign col_word[COL_ADDR_BITS + i] = bank[i];
  end
  assign col_word[BUS_W-1] = bank[BANK_W-1];

  // lane select, one-hot active high: bit 0 for even, bit 1 for odd
  assign lane_sel = offset[0] ? 2'b10 : 2'b01;

endmodule

// File: rtl/dram_strobe_fsm.sv
module dram_strobe_fsm
  import dram_seq_pkg::*;
#(
  parameter int BUS_W      = 9,
  parameter int COL_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             write,
  input  logic [1:0]       lane_sel,
  input  logic             phase_hi,
  input  logic [BUS_W-1:0] row_word,
  input  logic [BUS_W-1:0] col_word,
  output logic             idle,
  output logic [BUS_W-1:0] mux_addr,
  output logic             row_n,
  output logic             col_n,
  output logic [1:0]       we_n
);

  localparam int CNT_W = (COL_CYCLES > 1) ? $clog2(COL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COL_CYCLES - 1);

  seq_state_t       state;
  logic [BUS_W-1:0] col_hold;
  logic [1:0]       lane_hold;
  logic             wr_hold;
  logic [CNT_W-1:0] cnt;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mux_addr  <= '0;
      col_hold  <= '0;
      lane_hold <= 2'b00;
      wr_hold   <= 1'b0;
      cnt       <= '0;
      row_n     <= 1'b1;
      col_n     <= 1'b1;
      we_n      <= LANES_OFF;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            mux_addr  <= row_word;
            col_hold  <= col_word;
            lane_hold <= lane_sel;
            wr_hold   <= write;
            state     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (phase_hi) begin
            row_n <= 1'b0;
            state <= ST_RHOLD;
          end
        end
        ST_RHOLD: begin
          mux_addr <= col_hold;
          state    <= ST_CSET;
        end
        ST_CSET: begin
          col_n <= 1'b0;
          if (wr_hold) we_n <= ~lane_hold;
          cnt   <= CNT_LOAD;
          state <= ST_CACT;
        end
        ST_CACT: begin
          if (cnt == '0) begin
            we_n  <= LANES_OFF;
            state <= ST_CREL;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CREL: begin
          row_n <= 1'b1;
          col_n <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq #(
  parameter int OFFSET_W   = 13,
  parameter int BANK_W     = 5,
  parameter int BUS_W      = 9,
  parameter int COL_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [OFFSET_W-1:0] req_offset,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic                phase_hi,
  output logic [BUS_W-1:0]    mux_addr,
  output logic                row_stb_n,
  output logic                col_stb_n,
  output logic [1:0]          lane_we_n
);

  logic [BUS_W-1:0] row_word;
  logic [BUS_W-1:0] col_word;
  logic [1:0]       lane_sel;
  logic             idle;
  logic             start;

  dram_addr_map #(
    .OFFSET_W(OFFSET_W),
    .BANK_W  (BANK_W),
    .BUS_W   (BUS_W)
  ) u_map (
    .offset  (req_offset),
    .bank    (req_bank),
    .row_word(row_word),
    .col_word(col_word),
    .lane_sel(lane_sel)
  );

  assign req_ready = idle;
  assign start     = req_valid & idle;

  dram_strobe_fsm #(
    .BUS_W     (BUS_W),
    .COL_CYCLES(COL_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .write   (req_write),
    .lane_sel(lane_sel),
    .phase_hi(phase_hi),
    .row_word(row_word),
    .col_word(col_word),
    .idle    (idle),
    .mux_addr(mux_addr),
    .row_n   (row_stb_n),
    .col_n   (col_stb_n),
    .we_n    (lane_we_n)
  );

endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker #(
  parameter int BUS_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             phase_hi,
  input logic [BUS_W-1:0] mux_addr,
  input logic             row_stb_n,
  input logic             col_stb_n,
  input logic [1:0]       lane_we_n
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (row_stb_n && col_stb_n && lane_we_n == 2'b11));

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_row_on_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb_n) |-> $past(phase_hi));

  p_row_bus_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb_n) |-> $stable(mux_addr));

  p_col_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_stb_n) |-> (!row_stb_n && !$past(row_stb_n) && !$past(row_stb_n, 2)));

  p_col_bus_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !col_stb_n |-> $stable(mux_addr));

  p_we_in_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we_n != 2'b11) |-> (!col_stb_n && !row_stb_n));

  p_we_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~lane_we_n));

  p_end_together_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_stb_n) |-> ($rose(row_stb_n) && $past(lane_we_n) == 2'b11));

endmodule

bind dram_addr_seq dram_seq_checker #(.BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .phase_hi (phase_hi),
  .mux_addr (mux_addr),
  .row_stb_n(row_stb_n),
  .col_stb_n(col_stb_n),
  .lane_we_n(lane_we_n)
);

// File: tb/dram_addr_seq_bench.sv
module dram_addr_seq_bench;

  localparam int CLK_P      = 10;
  localparam int COL_CYCLES = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [12:0] req_offset = '0;
  logic [4:0]  req_bank = '0;
  logic        phase_hi = 1'b1;
  logic [8:0]  mux_addr;
  logic        row_stb_n;
  logic        col_stb_n;
  logic [1:0]  lane_we_n;

  int vecs = 0;
  int miss = 0;

  always #(CLK_P/2) clk = ~clk;

  dram_addr_seq #(.COL_CYCLES(COL_CYCLES)) u_dram_addr_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_bank(req_bank), .phase_hi(phase_hi),
    .mux_addr(mux_addr), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .lane_we_n(lane_we_n)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // one access, compared clock by clock; sample k follows capture edge + k
  task automatic run_access(input logic [12:0] off, input logic [4:0] bank,
                            input logic wr, input int wait_e, input bit hold_busy,
                            output logic [8:0] seen_row, output logic [8:0] seen_col);
    logic [8:0] rw;
    logic [8:0] cw;
    logic [1:0] we_act;
    int f;
    int last;
    rw     = {bank[4], off[8:1]};
    cw     = {bank[4], bank[3:0], off[12:9]};
    we_act = wr ? (off[0] ? 2'b01 : 2'b10) : 2'b11;
    f      = wait_e + 1;
    last   = f + 3 + COL_CYCLES;
    seen_row = '0;
    seen_col = '0;
    @(negedge clk);
    req_valid  = 1'b1;
    req_offset = off;
    req_bank   = bank;
    req_write  = wr;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (!hold_busy) req_valid = 1'b0;
        else begin
          req_offset = ~off;
          req_bank   = ~bank;
          req_write  = ~wr;
        end
      end
      chk("R2 ready", {15'd0, req_ready}, {15'd0, (k == last)});
      chk("R5 row strobe", {15'd0, row_stb_n}, {15'd0, !(k >= f && k < last)});
      chk("R9 col strobe", {15'd0, col_stb_n}, {15'd0, !(k >= f + 2 && k < last)});
      if (wr) chk("R8 write lane", {14'd0, lane_we_n},
                  {14'd0, (k >= f + 2 && k <= f + 1 + COL_CYCLES) ? we_act : 2'b11});
      else    chk("R7 read lanes", {14'd0, lane_we_n}, 16'd3);
      if (k <= f) chk("R3 row word", {7'd0, mux_addr}, {7'd0, rw});
      else        chk("R4 col word", {7'd0, mux_addr}, {7'd0, cw});
      if (k == f) seen_row = mux_addr;
      if (k == f + 1) begin
        seen_col = mux_addr;
        chk("R6 switch before col strobe", {6'd0, mux_addr, col_stb_n}, {6'd0, cw, 1'b1});
      end
      phase_hi = (k >= wait_e);
      if (k == last) req_valid = 1'b0;
    end
    phase_hi = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 ready", {15'd0, req_ready}, 16'd1);
    chk("R1 strobes", {14'd0, row_stb_n, col_stb_n}, 16'd3);
    chk("R1 lanes", {14'd0, lane_we_n}, 16'd3);
  endtask

  task automatic t_read_basic;
    logic [8:0] r, c;
    run_access(13'h1A5E, 5'h0B, 1'b0, 0, 1'b0, r, c);
    chk("R1 idle after read", {13'd0, row_stb_n, col_stb_n, req_ready}, 16'd7);
  endtask

  task automatic t_write_even;
    logic [8:0] r, c;
    run_access(13'h0F32, 5'h13, 1'b1, 0, 1'b0, r, c);
  endtask

  task automatic t_write_odd;
    logic [8:0] r, c;
    run_access(13'h10C7, 5'h05, 1'b1, 1, 1'b0, r, c);
  endtask

  task automatic t_phase_wait;
    logic [8:0] r, c;
    run_access(13'h0AAA, 5'h1F, 1'b1, 4, 1'b0, r, c);
  endtask

  task automatic t_busy_ignored;
    logic [8:0] r, c;
    run_access(13'h0555, 5'h0A, 1'b0, 3, 1'b1, r, c);
    @(negedge clk);
    chk("R2 no stray capture", {15'd0, req_ready}, 16'd1);
  endtask

  task automatic t_bank_top;
    logic [8:0] r0, c0, r1, c1;
    run_access(13'h1FFF, 5'h0F, 1'b0, 0, 1'b0, r0, c0);
    run_access(13'h0000, 5'h10, 1'b1, 0, 1'b0, r1, c1);
    chk("R4 top bank bit in both words", {7'd0, r1[8], c1[8], c1[7:0], r1[7:0] == 8'd0},
        {7'd0, 1'b1, 1'b1, 8'd0, 1'b1});
  endtask

  task automatic t_bit0_invisible;
    logic [8:0] ra, ca, rb, cb;
    run_access(13'h0B6C, 5'h16, 1'b0, 0, 1'b0, ra, ca);
    run_access(13'h0B6D, 5'h16, 1'b0, 0, 1'b0, rb, cb);
    chk("R10 row word same", {7'd0, rb}, {7'd0, ra});
    chk("R10 col word same", {7'd0, cb}, {7'd0, ca});
  endtask

  initial begin
    #(CLK_P * 20000);
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_write_even();
    t_write_odd();
    t_phase_wait();
    t_busy_ignored();
    t_bank_top();
    t_bit0_invisible();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule